// File: doc/BRIEF.md
# Sampling Clock Ratio Monitor

This block watches a slow, asynchronous sampling clock from the point of view of a faster bus clock. It raises an error when the sampling clock runs too slowly for the consumer that depends on it. The limit is one sixteenth of the bus clock frequency. Rising edges of the sampling clock are brought into the bus clock domain through a synchronizer and an edge detector. A fixed sixteen-cycle bus-clock window then decides whether the sampling clock kept up.

Two results are produced. The first is a live error bit that follows the clock condition: it rises when a whole window passes without an edge, and it falls on its own once a window sees an edge again. The second is a sticky interrupt flag. It latches only on the cycle in which the live bit rises, and it stays latched until software clears it. A disable input turns detection off and forces both outputs low. The monitor only reports. It has no path into any data it sits beside, so an error never stalls or alters that data.

Top module: `clk_ratio_monitor`

## Requirements
- R1: After reset is released, `clk_err` and `clk_err_irq` are both 0.
- R2: While `det_dis` is 1, `clk_err` and `clk_err_irq` read 0 on the next bus clock, and they stay 0 whatever the sampling clock does. Detection runs only while `det_dis` is 0.
- R3: When detection is on and a full 16-cycle bus-clock window passes without a synchronized rising edge of `samp_clk`, `clk_err` becomes 1 at the end of that window.
- R4: `clk_err` clears by itself at the end of the first window that contains a rising edge of `samp_clk`. It changes value at most once per window.
- R5: `clk_err_irq` goes from 0 to 1 only on the bus clock edge at which `clk_err` goes from 0 to 1.
- R6: Once set, `clk_err_irq` stays 1 until `irq_clr` is sampled as 1. A clear issued while `clk_err` remains 1 leaves the flag at 0 until `clk_err` rises again.
- R7: If `irq_clr` is 1 on the same cycle that `clk_err` rises, the flag is still set, because the set has priority over the clear.
- R8: A sampling clock whose period is at most 16 bus cycles, with high and low phases of at least two bus cycles each, never raises `clk_err`. A period of 17 bus cycles does raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock, the reference and register clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| samp_clk | input | 1 | Sampling clock under watch, asynchronous to `bus_clk` |
| det_dis | input | 1 | 1 disables detection and clears both outputs; 0 enables detection |
| irq_clr | input | 1 | Software clear pulse for the sticky flag, synchronous to `bus_clk` |
| clk_err | output | 1 | Live clock-error status, clears by itself |
| clk_err_irq | output | 1 | Sticky clock-error interrupt flag |

## Verification
The properties assume that `det_dis` and `irq_clr` are synchronous to `bus_clk`. They also assume that each phase of `samp_clk` lasts longer than one bus period, so that every rising edge survives the synchronizer. The stimulus changes `samp_clk` only on falling bus clock edges, in whole numbers of bus cycles per phase, with every phase at least two cycles long. The boundary sits between periods of 16 and 17 bus cycles. Long stops of the sampling clock, clears placed on the exact cycle of a rising error, and toggling of the disable input under a stopped clock are all driven explicitly.

// File: rtl/crm_pkg.sv
package crm_pkg;
  // Length of the observation window in bus clock cycles (bus/16 limit)
  localparam int unsigned WIN_LEN      = 16;
  // Number of flops in each synchronizer chain
  localparam int unsigned SYNC_STAGES  = 2;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/crm_rst_sync.sv
module crm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/crm_edge_sync.sv
module crm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_comb sync_d[gi] = async_i;
      end else begin : g_next
        always_comb sync_d[gi] = sync_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/crm_window.sv
module crm_window #(
  parameter int unsigned WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic rise_i,
  output logic win_end_o,
  output logic quiet_o
);
  localparam int unsigned CW = crm_pkg::cnt_width(WIN);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (!run_i) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (at_last) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      seen_d = seen_q | rise_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign win_end_o = run_i & at_last;
  assign quiet_o   = ~(seen_q | rise_i);
endmodule

// File: rtl/crm_flags.sv
module crm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic win_end_i,
  input  logic quiet_i,
  input  logic clr_i,
  output logic live_o,
  output logic sticky_o
);
  logic live_q, live_d;
  logic sticky_q, sticky_d;
  logic set_evt;

  assign set_evt = run_i & win_end_i & quiet_i & ~live_q;

  always_comb begin
    live_d   = live_q;
    sticky_d = sticky_q;
    if (!run_i) begin
      live_d   = 1'b0;
      sticky_d = 1'b0;
    end else begin
      if (win_end_i) live_d = quiet_i;
      if (set_evt)     sticky_d = 1'b1;
      else if (clr_i)  sticky_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      live_q   <= live_d;
      sticky_q <= sticky_d;
    end
  end

  assign live_o   = live_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor #(
  parameter int unsigned WIN_LEN     = crm_pkg::WIN_LEN,
  parameter int unsigned SYNC_STAGES = crm_pkg::SYNC_STAGES
) (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic samp_clk,
  input  logic det_dis,
  input  logic irq_clr,
  output logic clk_err,
  output logic clk_err_irq
);
  logic rst_n_s;
  logic run;
  logic rise;
  logic win_end;
  logic quiet;

  assign run = ~det_dis;

  crm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (bus_clk),
    .arst_n  (bus_rst_n),
    .rst_n_o (rst_n_s)
  );

  crm_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (bus_clk),
    .rst_n   (rst_n_s),
    .async_i (samp_clk),
    .rise_o  (rise)
  );

  crm_window #(.WIN(WIN_LEN)) u_win (
    .clk       (bus_clk),
    .rst_n     (rst_n_s),
    .run_i     (run),
    .rise_i    (rise),
    .win_end_o (win_end),
    .quiet_o   (quiet)
  );

  crm_flags u_flags (
    .clk       (bus_clk),
    .rst_n     (rst_n_s),
    .run_i     (run),
    .win_end_i (win_end),
    .quiet_i   (quiet),
    .clr_i     (irq_clr),
    .live_o    (clk_err),
    .sticky_o  (clk_err_irq)
  );
endmodule

// File: rtl/clk_ratio_monitor_sva.sv
module clk_ratio_monitor_sva (
  input logic bus_clk,
  input logic bus_rst_n,
  input logic det_dis,
  input logic irq_clr,
  input logic clk_err,
  input logic clk_err_irq
);
  // R2: disabling forces both outputs low on the next edge
  a_r2_disabled_quiet: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    det_dis |=> (!clk_err && !clk_err_irq));

  // R5: the flag only rises together with the live status
  a_r5_flag_rise_with_live: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(clk_err_irq) |-> $rose(clk_err));

  // R7: a rising live status always leaves the flag set
  a_r7_set_beats_clear: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(clk_err) |-> clk_err_irq);

  // R6: without a clear or a disable the flag holds
  a_r6_flag_holds: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (clk_err_irq && !irq_clr && !det_dis) |=> clk_err_irq);

  // R4: the live status changes at most once per window
  a_r4_live_once_per_window: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (!$stable(clk_err) && !det_dis) |=> $stable(clk_err));
endmodule

bind clk_ratio_monitor clk_ratio_monitor_sva u_sva (
  .bus_clk     (bus_clk),
  .bus_rst_n   (bus_rst_n),
  .det_dis     (det_dis),
  .irq_clr     (irq_clr),
  .clk_err     (clk_err),
  .clk_err_irq (clk_err_irq)
);

// File: tb/clk_ratio_monitor_tb.sv
module clk_ratio_monitor_tb;
  logic bus_clk;
  logic bus_rst_n;
  logic samp_clk;
  logic det_dis;
  logic irq_clr;
  logic clk_err;
  logic clk_err_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  // sampling clock shape in bus cycles; hi_len == 0 means stopped low
  int hi_len = 0;
  int lo_len = 0;
  int ph_cnt = 0;

  clk_ratio_monitor u_dut (
    .bus_clk     (bus_clk),
    .bus_rst_n   (bus_rst_n),
    .samp_clk    (samp_clk),
    .det_dis     (det_dis),
    .irq_clr     (irq_clr),
    .clk_err     (clk_err),
    .clk_err_irq (clk_err_irq)
  );

  initial bus_clk = 1'b0;
  always #5 bus_clk = ~bus_clk;

  // sampling clock generator, moves only on falling bus edges
  always @(negedge bus_clk) begin
    if (hi_len == 0) begin
      samp_clk <= 1'b0;
      ph_cnt   <= 0;
    end else begin
      if (ph_cnt + 1 >= (samp_clk ? hi_len : lo_len)) begin
        samp_clk <= ~samp_clk;
        ph_cnt   <= 0;
      end else begin
        ph_cnt <= ph_cnt + 1;
      end
    end
  end

  // behavioural reference model
  bit ra = 0, rb = 0;
  bit h1 = 0, h2 = 0, h3 = 0;
  int m_win = 0;
  bit m_seen = 0;
  bit m_live = 0;
  bit m_flag = 0;

  always @(posedge bus_clk) begin
    bit act, rise, nlive;
    cycles++;
    if (!bus_rst_n) begin
      ra = 0; rb = 0; h1 = 0; h2 = 0; h3 = 0;
      m_win = 0; m_seen = 0; m_live = 0; m_flag = 0;
    end else begin
      act = rb;
      rb = ra;
      ra = 1;
      if (!act) begin
        h1 = 0; h2 = 0; h3 = 0;
        m_win = 0; m_seen = 0; m_live = 0; m_flag = 0;
      end else begin
        rise = h2 && !h3;
        h3 = h2; h2 = h1; h1 = samp_clk;
        if (det_dis) begin
          m_win = 0; m_seen = 0; m_live = 0; m_flag = 0;
        end else if (m_win == 15) begin
          nlive = !(m_seen || rise);
          if (nlive && !m_live) m_flag = 1;
          else if (irq_clr) m_flag = 0;
          m_live = nlive;
          m_win = 0; m_seen = 0;
        end else begin
          m_win++;
          m_seen = m_seen || rise;
          if (irq_clr) m_flag = 0;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, got, exp, cycles);
    end
  endtask

  // compare on every falling edge
  always @(negedge bus_clk) begin
    if (cmp_on) begin
      check(cur_req, "clk_err", clk_err, m_live);
      check(cur_req, "clk_err_irq", clk_err_irq, m_flag);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge bus_clk);
      #2;
    end
  endtask

  // explicit point check away from the edge
  task automatic expect_now(input string req, input logic e_live, input logic e_flag);
    #1;
    check(req, "clk_err point", clk_err, e_live);
    check(req, "clk_err_irq point", clk_err_irq, e_flag);
  endtask

  // watchdog
  initial begin
    #1500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    bus_rst_n = 1'b1;
    samp_clk  = 1'b0;
    det_dis   = 1'b0;
    irq_clr   = 1'b0;
    #1 bus_rst_n = 1'b0;
    step(3);
    bus_rst_n = 1'b1;
    hi_len = 4; lo_len = 4;
    step(4);
    cmp_on = 1'b1;
    cur_req = "R1";
    expect_now("R1", 1'b0, 1'b0);

    // fast clock, period 8
    cur_req = "R8";
    step(100);
    expect_now("R8", 1'b0, 1'b0);

    // stop the clock: error must appear
    cur_req = "R3";
    hi_len = 0;
    step(40);
    expect_now("R3", 1'b1, 1'b1);
    expect_now("R5", 1'b1, 1'b1);

    // clear while error persists
    cur_req = "R6";
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    step(40);
    expect_now("R6", 1'b1, 1'b0);

    // resume: live clears by itself, flag stays low
    cur_req = "R4";
    hi_len = 3; lo_len = 3;
    step(50);
    expect_now("R4", 1'b0, 1'b0);

    // second error: flag holds after live recovers
    cur_req = "R6";
    hi_len = 0; step(40);
    hi_len = 5; lo_len = 5; step(60);
    expect_now("R6", 1'b0, 1'b1);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    step(2);
    expect_now("R6", 1'b0, 1'b0);

    // set beats clear: hold clear high through an error onset
    cur_req = "R7";
    irq_clr = 1'b1;
    hi_len = 0;
    step(40);
    irq_clr = 1'b0;
    step(5);
    expect_now("R7", 1'b1, 1'b0);
    hi_len = 2; lo_len = 2; step(50);

    // boundary: period 16 never errors
    cur_req = "R8";
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    hi_len = 8; lo_len = 8;
    step(200);
    expect_now("R8", 1'b0, 1'b0);

    // period 17 errors at some window
    hi_len = 8; lo_len = 9;
    step(400);
    expect_now("R8", clk_err, 1'b1);

    // disable with stopped clock: outputs forced low
    cur_req = "R2";
    hi_len = 0;
    step(40);
    det_dis = 1'b1;
    step(2);
    expect_now("R2", 1'b0, 1'b0);
    step(60);
    expect_now("R2", 1'b0, 1'b0);
    det_dis = 1'b0;
    step(40);
    expect_now("R3", 1'b1, 1'b1);
    det_dis = 1'b1; step(1); det_dis = 1'b0;
    step(10);
    expect_now("R2", 1'b0, 1'b0);
    step(20);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule